// File: doc/BRIEF.md
# Shared-Pin General-Purpose Port

An eight-bit general-purpose I/O port whose pins can be lent to on-chip peripherals. Software controls the port through a small register bus with two addresses: a latched output-data register and a direction register. On its own, each pin is driven from the data register when its direction bit is 1. When the direction bit is 0, the pin is an input, and its synchronised level is what a data read returns for that bit.

Three peripherals can take fixed pin groups, and an enabled peripheral always wins over ordinary I/O. A two-wire serial bus takes bits 7 (clock) and 6 (data) and drives them open-drain. An asynchronous serial unit takes bit 5 as its receive input and bit 4 as its transmit output. Two analog-output channels each take one pin, channel 1 on bit 1 and channel 0 on bit 0, and the digital buffer of that pin is switched off while its channel is enabled. Bits 3 and 2 stay ordinary I/O at all times. Pull-up requests are generated for the upper four pins whenever they are not driven. Every pin input passes through a two-flop synchroniser before it reaches the read path or a peripheral.

Top module: `pin_share_port`

## Requirements
- R1: After reset, the data register and the direction register both read 0x00. With no peripheral enabled, pin_oe is 0x00 and pin_pu is 0xF0.
- R2: While twi_en is 1, pin_out[7:6] is 0, pin_oe[7] equals twi_scl_low and pin_oe[6] equals twi_sda_low, whatever the data and direction registers hold.
- R3: While uart_en is 1, pin 5 is an input (pin_oe[5]=0, pin_out[5]=0) and pin 4 is an output (pin_oe[4]=1) with pin_out[4] equal to uart_txd.
- R4: While dac1_en is 1, pin 1 has pin_oe[1]=0 and pin_out[1]=0. While dac0_en is 1, the same holds for pin 0. Each enable acts only on its own pin.
- R5: pin_pu[i] is 1 for i in 7..4 exactly when pin_oe[i] is 0. pin_pu[3:0] is always 0.
- R6: A read at bus_addr=0 returns, for each bit, the data register bit where the direction bit is 1 and the synchronised pin level where it is 0. A read at bus_addr=1 returns the direction register. Writes with bus_wr=1 take effect at the next rising clock edge, at either address and at any time.
- R7: A pin level sampled at a rising edge reaches the read data and the peripheral inputs (twi_scl_in=pin 7, twi_sda_in=pin 6, uart_rxd=pin 5) after the second rising edge.
- R8: A pin that no enabled peripheral owns has pin_out equal to its data bit and pin_oe equal to its direction bit. Bits 3 and 2 always behave this way.
- R9: On a pin owned by an enabled peripheral, the direction and data registers have no effect on pin_out or pin_oe. The registers keep their values, and the pin behaves per R8 again once the peripheral is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 1 | 0 = data register, 1 = direction register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output values |
| pin_oe | output | 8 | Pad output enables |
| pin_pu | output | 8 | Pad pull-up enables |
| twi_en | input | 1 | Two-wire bus owns pins 7:6 |
| twi_scl_low | input | 1 | Two-wire bus pulls clock low |
| twi_sda_low | input | 1 | Two-wire bus pulls data low |
| twi_scl_in | output | 1 | Synchronised clock line level |
| twi_sda_in | output | 1 | Synchronised data line level |
| uart_en | input | 1 | Serial unit owns pins 5:4 |
| uart_txd | input | 1 | Serial transmit data |
| uart_rxd | output | 1 | Synchronised receive data |
| dac1_en | input | 1 | Analog channel 1 owns pin 1 |
| dac0_en | input | 1 | Analog channel 0 owns pin 0 |

## Verification
The port is driven with random data and direction values under every combination of the four peripheral enables. This separates ownership of each pin group from plain I/O and shows that one analog enable leaves the other pin alone. Random pin levels stepped every cycle, together with mixed direction masks, test the per-bit choice between the latched value and the pin level, and expose any synchroniser that is one stage short or one stage long. The open-drain request lines and the transmit data are toggled on their own, so an override that ignores the peripheral's own signal is caught. Registers are written while owned and read back after release to confirm that the port state is preserved.

// File: rtl/pin_share_pkg.sv
// Package: shared widths and fixed pin positions of the shared-pin port.
// Assumes an eight-pin port; pin positions are behaviour (neighbours decode them).
package pin_share_pkg;
    localparam int PORT_W   = 8;
    localparam int SYNC_LEN = 2;
    localparam int PIN_SCL  = 7;
    localparam int PIN_SDA  = 6;
    localparam int PIN_RXD  = 5;
    localparam int PIN_TXD  = 4;
    localparam int PIN_AO1  = 1;
    localparam int PIN_AO0  = 0;
    localparam logic [PORT_W-1:0] PULL_MASK = 8'hF0;

    typedef struct packed {
        logic twi_en;
        logic twi_scl_low;
        logic twi_sda_low;
        logic uart_en;
        logic uart_txd;
        logic dac1_en;
        logic dac0_en;
    } periph_ctl_t;
endpackage

// File: rtl/pin_share_regs.sv
// Module: data and direction registers of the port.
// Assumes a single-cycle write strobe; both registers reset to zero synchronously.
module pin_share_regs #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         wr_addr,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] data_q,
    output logic [W-1:0] dir_q
);
    // Register update: address 0 loads data, address 1 loads direction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr) dir_q  <= wr_data;
            else         data_q <= wr_data;
        end
    end
endmodule

// File: rtl/pin_share_sync.sv
// Module: per-pin multi-flop input synchroniser.
// Assumes pad inputs are asynchronous; every stage resets to zero.
module pin_share_sync #(
    parameter int W   = 8,
    parameter int LEN = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage [LEN];

    genvar g;
    generate
        for (g = 0; g < LEN; g++) begin : g_stage
            // One synchroniser stage, fed by the pad or by the previous stage.
            always_ff @(posedge clk) begin
                if (!rst_n)      stage[g] <= '0;
                else if (g == 0) stage[g] <= raw_in;
                else             stage[g] <= stage[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign sync_out = stage[LEN-1];
endmodule

// File: rtl/pin_share_mux.sv
// Module: per-pin ownership mux between ordinary I/O and the peripherals.
// Assumes fixed pin positions from the package; purely combinational.
module pin_share_mux
    import pin_share_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [W-1:0] data_q,
    input  logic [W-1:0] dir_q,
    input  periph_ctl_t  ctl,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_pu
);
    logic [W-1:0] gp_out, gp_oe;

    // Start from ordinary I/O, then apply each enabled peripheral's claim.
    always_comb begin
        gp_out = data_q;
        gp_oe  = dir_q;
        if (ctl.twi_en) begin
            gp_out[PIN_SCL] = 1'b0;
            gp_oe[PIN_SCL]  = ctl.twi_scl_low;
            gp_out[PIN_SDA] = 1'b0;
            gp_oe[PIN_SDA]  = ctl.twi_sda_low;
        end
        if (ctl.uart_en) begin
            gp_out[PIN_RXD] = 1'b0;
            gp_oe[PIN_RXD]  = 1'b0;
            gp_out[PIN_TXD] = ctl.uart_txd;
            gp_oe[PIN_TXD]  = 1'b1;
        end
        if (ctl.dac1_en) begin
            gp_out[PIN_AO1] = 1'b0;
            gp_oe[PIN_AO1]  = 1'b0;
        end
        if (ctl.dac0_en) begin
            gp_out[PIN_AO0] = 1'b0;
            gp_oe[PIN_AO0]  = 1'b0;
        end
    end

    assign pin_out = gp_out;
    assign pin_oe  = gp_oe;

    genvar i;
    generate
        for (i = 0; i < W; i++) begin : g_pull
            // Pull-up only on pull-capable pins while the pin is not driven.
            if (PULL_MASK[i]) begin : g_on
                assign pin_pu[i] = ~gp_oe[i];
            end else begin : g_off
                assign pin_pu[i] = 1'b0;
            end
        end
    endgenerate
endmodule

// File: rtl/pin_share_port.sv
// Module: top of the shared-pin port: registers, synchroniser, mux, read path.
// Assumes synchronous active-low reset and a combinational read of the addressed register.
module pin_share_port
    import pin_share_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0] pin_pu,
    input  logic              twi_en,
    input  logic              twi_scl_low,
    input  logic              twi_sda_low,
    output logic              twi_scl_in,
    output logic              twi_sda_in,
    input  logic              uart_en,
    input  logic              uart_txd,
    output logic              uart_rxd,
    input  logic              dac1_en,
    input  logic              dac0_en
);
    logic [PORT_W-1:0] data_q, dir_q, pin_sync, data_view;
    periph_ctl_t       ctl;

    assign ctl = '{twi_en: twi_en, twi_scl_low: twi_scl_low, twi_sda_low: twi_sda_low,
                   uart_en: uart_en, uart_txd: uart_txd,
                   dac1_en: dac1_en, dac0_en: dac0_en};

    pin_share_regs #(.W(PORT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
        .wr_data(bus_wdata), .data_q(data_q), .dir_q(dir_q)
    );

    pin_share_sync #(.W(PORT_W), .LEN(SYNC_LEN)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(pin_in), .sync_out(pin_sync)
    );

    pin_share_mux #(.W(PORT_W)) u_mux (
        .data_q(data_q), .dir_q(dir_q), .ctl(ctl),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu)
    );

    genvar b;
    generate
        for (b = 0; b < PORT_W; b++) begin : g_view
            // Per bit: latched value for outputs, synchronised pin for inputs.
            assign data_view[b] = dir_q[b] ? data_q[b] : pin_sync[b];
        end
    endgenerate

    // Read mux between the two addresses.
    assign bus_rdata  = bus_addr ? dir_q : data_view;
    assign twi_scl_in = pin_sync[PIN_SCL];
    assign twi_sda_in = pin_sync[PIN_SDA];
    assign uart_rxd   = pin_sync[PIN_RXD];
endmodule

// File: rtl/pin_share_port_chk.sv
// Checker: temporal properties of the shared-pin port, bound to the top.
// Assumes the top's port names; holds its own cycle counter for the synchroniser window.
module pin_share_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] pin_in,
    input logic [7:0] pin_out,
    input logic [7:0] pin_oe,
    input logic [7:0] pin_pu,
    input logic       twi_en,
    input logic       twi_scl_low,
    input logic       uart_en,
    input logic       uart_txd,
    input logic       dac0_en,
    input logic       dac1_en,
    input logic       twi_scl_in,
    input logic       uart_rxd
);
    logic [1:0] since_rst;

    // Count cycles out of reset, saturating once the synchroniser is full.
    always_ff @(posedge clk) begin
        if (!rst_n)               since_rst <= 2'd0;
        else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end

    a_r2_twi_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        twi_en |-> (pin_out[7:6] == 2'b00 && pin_oe[7] == twi_scl_low));
    a_r3_uart_pins: assert property (@(posedge clk) disable iff (!rst_n)
        uart_en |-> (pin_oe[4] && !pin_oe[5] && pin_out[4] == uart_txd));
    a_r4_dac_buffers_off: assert property (@(posedge clk) disable iff (!rst_n)
        (dac0_en || dac1_en) |-> ((!dac0_en || !pin_oe[0]) && (!dac1_en || !pin_oe[1])));
    a_r5_pull_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu[3:0] == 4'h0) && ((pin_pu[7:4] & pin_oe[7:4]) == 4'h0));
    a_r7_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd2) |-> (twi_scl_in == $past(pin_in[7], 2) && uart_rxd == $past(pin_in[5], 2)));
endmodule

bind pin_share_port pin_share_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .pin_pu(pin_pu), .twi_en(twi_en), .twi_scl_low(twi_scl_low), .uart_en(uart_en),
    .uart_txd(uart_txd), .dac0_en(dac0_en), .dac1_en(dac1_en),
    .twi_scl_in(twi_scl_in), .uart_rxd(uart_rxd)
);

// File: tb/pin_share_port_bench.sv
// Bench: behavioural reference model of the port, compared after every clock.
module pin_share_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic [7:0] pin_in = 8'h00, pin_out, pin_oe, pin_pu;
    logic       twi_en = 0, twi_scl_low = 0, twi_sda_low = 0, twi_scl_in, twi_sda_in;
    logic       uart_en = 0, uart_txd = 0, uart_rxd, dac1_en = 0, dac0_en = 0;

    int total = 0, bad = 0;
    logic [7:0] m_data = 0, m_dir = 0;
    logic [7:0] m_hist [$];

    always #5 clk = ~clk;

    pin_share_port u_pin_share_port (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pin_pu(pin_pu),
        .twi_en(twi_en), .twi_scl_low(twi_scl_low), .twi_sda_low(twi_sda_low),
        .twi_scl_in(twi_scl_in), .twi_sda_in(twi_sda_in), .uart_en(uart_en),
        .uart_txd(uart_txd), .uart_rxd(uart_rxd), .dac1_en(dac1_en), .dac0_en(dac0_en)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    // Synchronised pin level per the model: the pin value two edges back.
    function automatic logic [7:0] m_sync();
        return m_hist[0];
    endfunction

    // Advance one clock: update the model at the edge, then compare all outputs.
    task automatic step();
        logic [7:0] eo, ee, ep, s;
        @(posedge clk);
        if (!rst_n) begin
            m_data = 0; m_dir = 0;
            m_hist = '{8'h00, 8'h00};
        end else begin
            m_hist.push_back(pin_in);
            void'(m_hist.pop_front());
            if (bus_wr) begin
                if (bus_addr) m_dir = bus_wdata; else m_data = bus_wdata;
            end
        end
        #2;
        s = m_sync();
        eo = m_data; ee = m_dir;
        if (twi_en)  begin eo[7] = 0; eo[6] = 0; ee[7] = twi_scl_low; ee[6] = twi_sda_low; end
        if (uart_en) begin eo[5] = 0; ee[5] = 0; eo[4] = uart_txd; ee[4] = 1; end
        if (dac1_en) begin eo[1] = 0; ee[1] = 0; end
        if (dac0_en) begin eo[0] = 0; ee[0] = 0; end
        ep = 8'h00;
        for (int i = 4; i < 8; i++) ep[i] = !ee[i];
        chk("R2 twi pins out",  {6'b0, pin_out[7:6]}, {6'b0, eo[7:6]});
        chk("R2 twi pins oe",   {6'b0, pin_oe[7:6]},  {6'b0, ee[7:6]});
        chk("R3 uart pins",     {4'b0, pin_out[5:4], pin_oe[5:4]}, {4'b0, eo[5:4], ee[5:4]});
        chk("R4 dac pins",      {4'b0, pin_out[1:0], pin_oe[1:0]}, {4'b0, eo[1:0], ee[1:0]});
        chk("R8 gpio pins 3:2", {4'b0, pin_out[3:2], pin_oe[3:2]}, {4'b0, eo[3:2], ee[3:2]});
        chk("R5 pull-ups",      pin_pu, ep);
        chk("R7 periph inputs", {5'b0, twi_scl_in, twi_sda_in, uart_rxd}, {5'b0, s[7], s[6], s[5]});
        if (bus_addr) chk("R6 dir read", bus_rdata, m_dir);
        else          chk("R6 data read", bus_rdata, (m_dir & m_data) | (~m_dir & s));
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step();
        bus_wr = 0;
    endtask

    initial begin
        m_hist = '{8'h00, 8'h00};
        // R1: reset state
        repeat (3) step();
        rst_n = 1;
        bus_addr = 0; step();
        chk("R1 data reset", bus_rdata, 8'h00);
        chk("R1 oe reset", pin_oe, 8'h00);
        chk("R1 pu reset", pin_pu, 8'hF0);
        bus_addr = 1; step();
        chk("R1 dir reset", bus_rdata, 8'h00);

        // R8/R6: plain I/O with fixed patterns
        wr(1, 8'hF0); wr(0, 8'hA5);
        pin_in = 8'h3C; repeat (3) step();
        bus_addr = 0; step();
        chk("R6 mixed read", bus_rdata, 8'hAC);
        chk("R8 gpio out", pin_out, 8'hA5);

        // R7: single-pin change latency
        pin_in = 8'h00; repeat (3) step();
        pin_in = 8'h80; step();
        chk("R7 one edge not yet", {7'b0, twi_scl_in}, 8'h00);
        step();
        chk("R7 two edges seen", {7'b0, twi_scl_in}, 8'h01);

        // Random sweep across every enable combination (R2 R3 R4 R5 R9)
        for (int k = 0; k < 1600; k++) begin
            if (k % 100 == 0) {twi_en, uart_en, dac1_en, dac0_en} = 4'(k / 100);
            pin_in = 8'($urandom);
            twi_scl_low = $urandom % 2; twi_sda_low = $urandom % 2;
            uart_txd = $urandom % 2;
            bus_addr = $urandom % 2;
            if ($urandom % 4 == 0) wr($urandom % 2, 8'($urandom));
            else step();
        end

        // R9: registers survive ownership and return control on release
        {twi_en, uart_en, dac1_en, dac0_en} = 4'hF;
        wr(1, 8'hFF); wr(0, 8'h5A);
        {twi_en, uart_en, dac1_en, dac0_en} = 4'h0;
        bus_addr = 1; step();
        chk("R9 dir kept", bus_rdata, 8'hFF);
        chk("R9 out restored", pin_out, 8'h5A);
        chk("R9 oe restored", pin_oe, 8'hFF);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #500000;
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule